// File: doc/BRIEF.md
# Configurable Simple Dual-Port RAM

A parameterized memory with one write port and one read port. The write side takes an address, a write strobe, per-lane byte enables and a data word on the write clock. The read side takes an address and a read enable and returns a word on the read clock. A shared active-low asynchronous clear resets the optional port registers. The stored words are never cleared. The memory starts all zeros.

Each port path can be fed straight through or placed behind one register, chosen by a parameter. The write address, the write strobe with its byte enables, and the write data can each be registered on the write clock or left combinational. The read address and read enable can each be combinational, registered on the write clock, or registered on the read clock. The read data can be combinational or registered on the read clock. Every register has its own parameter that decides whether the clear reaches it. The word count may be smaller than the address space allows.

When both clocks come from the same source and the output is registered, a read and a write to the same address on the same edge can be set to return the word before the write, the word after the write, or an unspecified word.

Top module: `sdp_ram`

## Requirements
- R1: The write address, the write strobe with its byte enables, and the write data each pass either through one write-clock register or straight through, and all three default to registered. Storage is updated on a write-clock edge from the values at the array.
- R2: The read address and read enable each pass straight through, or through a register on the write clock, or through a register on the read clock, and both default to the read clock.
- R3: The read data is either combinational from the array at the current read address, which is the default, or registered on the read clock.
- R4: With registered read data, the output register loads only on edges where the read enable at the array is 1 and otherwise holds. With combinational read data, a registered read address loads only on edges where `ren_i` is 1.
- R5: While `rst_ni` is 0, every register whose clear flag is set is forced to zero at once. A register whose flag is clear ignores `rst_ni`. Stored words are never cleared.
- R6: The word count WORDS must satisfy 2^(ADDR_W-1) < WORDS <= 2^ADDR_W and defaults to 2^ADDR_W. A write to an address >= WORDS changes nothing, and a read of such an address returns zero.
- R7: There are DATA_W/LANE_W byte lanes. Bit i of `wbe_i` enables the write of bits [i*LANE_W +: LANE_W], and disabled lanes keep their stored value.
- R8: Every word reads as zero until it is first written.
- R9: With the old-data collision mode and registered read data, a read of the address written on the same edge returns the word held before that write.
- R10: With the new-data collision mode and registered read data, such a read returns the word after the write, with the byte enables applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| waddr_i | input | ADDR_W | Write address |
| wen_i | input | 1 | Write strobe |
| wbe_i | input | DATA_W/LANE_W | Byte-lane write enables |
| wdata_i | input | DATA_W | Write data |
| raddr_i | input | ADDR_W | Read address |
| ren_i | input | 1 | Read enable |
| rdata_o | output | DATA_W | Read data |

## Verification
Four option sets are driven from one stimulus and compared every cycle against a behavioural model with the latency of each path. The bench targets these cases:
- Partial byte enables. A design that merges wrongly corrupts neighbouring lanes.
- Writes and reads at addresses above the word count. A bad bound aliases onto valid words or returns stale data.
- Read-enable gating. A design that ignores it lets the output or the address register follow a disabled read.
- Same-edge collisions under old-data and new-data modes. A mixed-up forward path returns the other mode's word.
- A clear pulse in mid-run. It exposes a read-data register that clears despite its flag being off, and shows any storage wrongly reset.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    STG_NONE = 2'd0,
    STG_WCLK = 2'd1,
    STG_RCLK = 2'd2
  } stg_sel_e;

  typedef enum logic [1:0] {
    RDW_DONT_CARE = 2'd0,
    RDW_OLD       = 2'd1,
    RDW_NEW       = 2'd2
  } rdw_e;
endpackage

// File: rtl/sdp_stage.sv
module sdp_stage import sdp_pkg::*; #(
  parameter int unsigned W   = 1,
  parameter stg_sel_e    SEL = STG_WCLK,
  parameter bit          CLR = 1'b1
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (SEL == STG_NONE) begin : g_pass
    logic unused_stg;
    assign unused_stg = ^{wclk_i, rclk_i, rst_ni, en_i};
    assign q_o = d_i;
  end else begin : g_reg
    logic         clk;
    logic [W-1:0] r;
    assign clk = (SEL == STG_WCLK) ? wclk_i : rclk_i;
    if (CLR) begin : g_clr
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)   r <= '0;
        else if (en_i) r <= d_i;
      end
    end else begin : g_keep
      logic unused_rst;
      assign unused_rst = rst_ni;
      always_ff @(posedge clk) begin
        if (en_i) r <= d_i;
      end
    end
    assign q_o = r;
  end
endmodule

// File: rtl/sdp_store.sv
module sdp_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORDS  = 16,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] fwd_o
);
  localparam logic [ADDR_W:0] WORDS_L = (ADDR_W+1)'(WORDS);

  logic [DATA_W-1:0] mem [WORDS] = '{default: '0};
  logic              w_hit, r_hit;
  logic [DATA_W-1:0] cur_w, merged;

  assign w_hit = we_i && ({1'b0, waddr_i} < WORDS_L);
  assign r_hit = {1'b0, raddr_i} < WORDS_L;
  assign cur_w = w_hit ? mem[waddr_i] : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] =
      wbe_i[g] ? wdata_i[g*LANE_W +: LANE_W] : cur_w[g*LANE_W +: LANE_W];

    AST_LANE_KEEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
      (w_hit && !wbe_i[g]) |=> (raddr_i != $past(raddr_i)) ||
        $stable(rdata_o[g*LANE_W +: LANE_W])) else $error("lane write leak"); // R7
  end

  always_ff @(posedge wclk_i) begin
    if (w_hit) mem[waddr_i] <= merged;
  end

  assign rdata_o = r_hit ? mem[raddr_i] : '0;
  // same-edge forward of the merged word for new-data mode
  assign fwd_o = (w_hit && (waddr_i == raddr_i)) ? merged : rdata_o;

  AST_WR_THEN_RD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_hit && &wbe_i) |=> (raddr_i != $past(waddr_i)) ||
      (rdata_o == $past(wdata_i))) else $error("write not visible"); // R1

  AST_OOR_IGNORED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (we_i && !w_hit) |=> (raddr_i != $past(raddr_i)) ||
      $stable(rdata_o)) else $error("out-of-range write landed"); // R6
endmodule

// File: rtl/sdp_ram.sv
module sdp_ram import sdp_pkg::*; #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned WORDS     = 1 << ADDR_W,
  parameter stg_sel_e    WADDR_SEL = STG_WCLK,
  parameter stg_sel_e    WEN_SEL   = STG_WCLK,
  parameter stg_sel_e    WDATA_SEL = STG_WCLK,
  parameter stg_sel_e    RADDR_SEL = STG_RCLK,
  parameter stg_sel_e    REN_SEL   = STG_RCLK,
  parameter stg_sel_e    Q_SEL     = STG_NONE,
  parameter bit          WADDR_CLR = 1'b1,
  parameter bit          WEN_CLR   = 1'b1,
  parameter bit          WDATA_CLR = 1'b1,
  parameter bit          RADDR_CLR = 1'b1,
  parameter bit          REN_CLR   = 1'b1,
  parameter bit          Q_CLR     = 1'b1,
  parameter rdw_e        RDW       = RDW_DONT_CARE,
  localparam int unsigned LANES    = DATA_W / LANE_W
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wen_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic              ren_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] WORDS_L = (ADDR_W+1)'(WORDS);

  logic [ADDR_W-1:0] waddr_s, raddr_s;
  logic [LANES:0]    wctl_s;
  logic              wen_s, ren_s, ra_load;
  logic [LANES-1:0]  wbe_s;
  logic [DATA_W-1:0] wdata_s, rd_word, fwd_word;

  assign wen_s = wctl_s[LANES];
  assign wbe_s = wctl_s[LANES-1:0];
  // combinational output: enable gates the address register instead
  assign ra_load = (Q_SEL == STG_NONE) ? ren_i : 1'b1;

  sdp_stage #(.W(ADDR_W), .SEL(WADDR_SEL), .CLR(WADDR_CLR)) u_waddr (
    .wclk_i, .rclk_i, .rst_ni, .en_i(1'b1), .d_i(waddr_i), .q_o(waddr_s));

  sdp_stage #(.W(LANES+1), .SEL(WEN_SEL), .CLR(WEN_CLR)) u_wctl (
    .wclk_i, .rclk_i, .rst_ni, .en_i(1'b1), .d_i({wen_i, wbe_i}), .q_o(wctl_s));

  sdp_stage #(.W(DATA_W), .SEL(WDATA_SEL), .CLR(WDATA_CLR)) u_wdata (
    .wclk_i, .rclk_i, .rst_ni, .en_i(1'b1), .d_i(wdata_i), .q_o(wdata_s));

  sdp_stage #(.W(1), .SEL(REN_SEL), .CLR(REN_CLR)) u_ren (
    .wclk_i, .rclk_i, .rst_ni, .en_i(1'b1), .d_i(ren_i), .q_o(ren_s));

  sdp_stage #(.W(ADDR_W), .SEL(RADDR_SEL), .CLR(RADDR_CLR)) u_raddr (
    .wclk_i, .rclk_i, .rst_ni, .en_i(ra_load), .d_i(raddr_i), .q_o(raddr_s));

  sdp_store #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_store (
    .wclk_i,
    .rst_ni,
    .we_i    (wen_s),
    .waddr_i (waddr_s),
    .wbe_i   (wbe_s),
    .wdata_i (wdata_s),
    .raddr_i (raddr_s),
    .rdata_o (rd_word),
    .fwd_o   (fwd_word)
  );

  if (Q_SEL == STG_NONE) begin : g_q_comb
    logic unused_q;
    assign unused_q = ^{ren_s, fwd_word};
    assign rdata_o = rd_word;
  end else begin : g_q_reg
    logic [DATA_W-1:0] q_d;
    assign q_d = (RDW == RDW_NEW) ? fwd_word : rd_word;

    sdp_stage #(.W(DATA_W), .SEL(Q_SEL), .CLR(Q_CLR)) u_q (
      .wclk_i, .rclk_i, .rst_ni, .en_i(ren_s), .d_i(q_d), .q_o(rdata_o));

    AST_Q_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      !ren_s |=> $stable(rdata_o)) else $error("q moved without enable"); // R4

    if (RDW == RDW_NEW) begin : g_new_chk
      AST_RDW_NEW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        (ren_s && wen_s && &wbe_s && (waddr_s == raddr_s) &&
         ({1'b0, waddr_s} < WORDS_L)) |=> (rdata_o == $past(wdata_s)))
        else $error("collision missed new word"); // R10
    end
  end
endmodule

// File: tb/sim_sdp_ram.sv
module sim_sdp_ram;
  import sdp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  wa, ra;
  logic        we, re;
  logic [1:0]  wbe;
  logic [15:0] wd;
  logic [15:0] q0, q1, q2, q3;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdp_ram #(.WORDS(NW)) u0 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .waddr_i(wa), .wen_i(we),
    .wbe_i(wbe), .wdata_i(wd), .raddr_i(ra), .ren_i(re), .rdata_o(q0));

  sdp_ram #(.WORDS(NW), .RADDR_SEL(STG_WCLK), .REN_SEL(STG_WCLK),
            .Q_SEL(STG_RCLK), .RDW(RDW_OLD)) u1 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .waddr_i(wa), .wen_i(we),
    .wbe_i(wbe), .wdata_i(wd), .raddr_i(ra), .ren_i(re), .rdata_o(q1));

  sdp_ram #(.WORDS(NW), .RADDR_SEL(STG_WCLK), .REN_SEL(STG_WCLK),
            .Q_SEL(STG_RCLK), .Q_CLR(1'b0), .RDW(RDW_NEW)) u2 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .waddr_i(wa), .wen_i(we),
    .wbe_i(wbe), .wdata_i(wd), .raddr_i(ra), .ren_i(re), .rdata_o(q2));

  sdp_ram #(.WORDS(NW), .WADDR_SEL(STG_NONE), .WEN_SEL(STG_NONE),
            .WDATA_SEL(STG_NONE), .RADDR_SEL(STG_NONE), .REN_SEL(STG_NONE),
            .Q_SEL(STG_NONE)) u3 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .waddr_i(wa), .wen_i(we),
    .wbe_i(wbe), .wdata_i(wd), .raddr_i(ra), .ren_i(re), .rdata_o(q3));

  // behavioural reference
  logic [15:0] ma [16];
  logic [15:0] mb [16];
  logic        p_en;
  logic [3:0]  p_a;
  logic [15:0] p_d;
  logic [1:0]  p_be;
  logic [3:0]  r0_a, r1_a;
  logic        r1_en;
  logic [15:0] e1, e2;
  logic        v2;

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] be);
    merge = old;
    if (be[0]) merge[7:0]  = d[7:0];
    if (be[1]) merge[15:8] = d[15:8];
  endfunction

  function automatic logic [15:0] rd_a(logic [3:0] a);
    rd_a = (int'(a) < NW) ? ma[a] : 16'h0;
  endfunction

  function automatic logic [15:0] rd_b(logic [3:0] a);
    rd_b = (int'(a) < NW) ? mb[a] : 16'h0;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin ma[i] = '0; mb[i] = '0; end
    p_en = 0; p_a = 0; p_d = 0; p_be = 0; r0_a = 0; r1_a = 0; r1_en = 0;
    e1 = 0; e2 = 0; v2 = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_en = 0; p_a = 0; p_d = 0; p_be = 0;
      r0_a = 0; r1_a = 0; r1_en = 0; e1 = 0;
    end else begin
      logic [15:0] old_w, new_w;
      old_w = rd_a(r1_a);
      if (p_en && int'(p_a) < NW) ma[p_a] = merge(ma[p_a], p_d, p_be);
      new_w = rd_a(r1_a);
      if (r1_en) begin e1 = old_w; e2 = new_w; v2 = 1'b1; end
      p_en = we; p_a = wa; p_d = wd; p_be = wbe;
      r1_a = ra; r1_en = re;
      if (re) r0_a = ra;
      if (we && int'(wa) < NW) mb[wa] = merge(mb[wa], wd, wbe);
    end
  end

  task automatic chk(string req, string who, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, who, got, exp);
    end
  endtask

  task automatic step(string tag);
    string t0, t1, t2;
    @(negedge clk);
    t0 = (tag == "RDW") ? "R3"  : tag;
    t1 = (tag == "RDW") ? "R9"  : tag;
    t2 = (tag == "RDW") ? "R10" : tag;
    chk(t0, "u0", q0, rd_a(r0_a));
    chk(t1, "u1", q1, e1);
    if (v2) chk(t2, "u2", q2, e2);
    chk(t0, "u3", q3, rd_b(ra));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; we = 0; wa = 0; wd = 0; wbe = 0; ra = 0; re = 0;
    @(negedge clk);
    step("R5");                       // reset state
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin // R8 untouched words read zero
      ra = 4'(i); re = 1; step("R8");
    end
    for (int i = 0; i < 40; i++) begin // R1 full-word writes
      we = 1; wa = 4'($urandom % NW); wd = 16'($urandom); wbe = 2'b11;
      ra = 4'($urandom % NW); re = 1; step("R1");
    end
    for (int i = 0; i < 40; i++) begin // R7 lane enables
      we = 1; wa = 4'($urandom % 4); wd = 16'($urandom); wbe = 2'($urandom);
      ra = 4'($urandom % 4); re = 1; step("R7");
    end
    for (int i = 0; i < 40; i++) begin // R6 addresses past the word count
      we = 1; wa = (i % 2 == 0) ? 4'(NW + $urandom % 4) : 4'($urandom % NW);
      wd = 16'($urandom); wbe = 2'b11; ra = 4'($urandom % 16); re = 1; step("R6");
    end
    for (int i = 0; i < 40; i++) begin // R4 read enable gating
      we = 1'($urandom); wa = 4'($urandom % NW); wd = 16'($urandom);
      wbe = 2'($urandom); ra = 4'($urandom % 16); re = 1'($urandom); step("R4");
    end
    for (int i = 0; i < 30; i++) begin // R9 R10 same-edge collisions
      we = 1; wa = 4'($urandom % NW); ra = wa; wd = 16'($urandom);
      wbe = 2'($urandom); re = 1; step("RDW");
    end
    for (int i = 0; i < 60; i++) begin // R2 mixed traffic
      we = 1'($urandom); wa = 4'($urandom % 16); wd = 16'($urandom);
      wbe = 2'($urandom); ra = 4'($urandom % 16); re = 1'($urandom); step("R2");
    end
    we = 0; re = 0;
    step("R5");
    rst_n = 0;                        // R5 clear in mid-run
    step("R5");
    step("R5");
    rst_n = 1;
    for (int i = 0; i < 30; i++) begin // R3 after clear
      we = 1'($urandom); wa = 4'($urandom % 16); wd = 16'($urandom);
      wbe = 2'($urandom); ra = 4'($urandom % 16); re = 1'($urandom); step("R3");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule